// File: doc/BRIEF.md
# Modified-Walsh M-ary Bi-orthogonal Chip Modulator

This block turns a stream of already-scrambled data bits into 8-chip spreading codewords for the two high-rate bi-orthogonal keying modes. Bits arrive one per handshake and are grouped into 4-bit sign-magnitude nibbles. The 3-bit magnitude of a nibble picks one of eight Walsh codewords. Each codeword is first XORed with a fixed mask, so that no codeword is all zeros, and then with the nibble's sign. Binary mode uses one nibble per symbol and sends the same codeword on both I and Q. Quaternary mode uses two nibbles per symbol: the first goes to Q and the second goes to I.

Every output chip is then XORed with a phase-reference bit supplied from outside. This lets a coherent receiver resolve the phase ambiguity without differential coding of the high-rate data. One chip leaves the block on each cycle where the chip enable is high, so the symbol rate is one eighth of the chip-enable rate. While the sequencer plays out a symbol, the collector gathers the bits for the next one. This allows consecutive symbols to be emitted with no gap between them.

Top module: `mbok_chip_modulator`

## Requirements
- R1: Of each nibble, the first three accepted bits form the magnitude (the first bit is the magnitude LSB) and the fourth accepted bit is the sign.
- R2: Magnitudes 0 to 7 select the codewords 0x03, 0x0C, 0x30, 0x3F, 0x56, 0x59, 0x65, 0x6A. Chip k of a symbol (k = 0 first) is bit k of the selected value.
- R3: A sign bit of 1 inverts every chip of that nibble's codeword.
- R4: In binary mode (`quad_mode`=0) each symbol takes one nibble, and `chip_i` equals `chip_q` on every valid chip.
- R5: In quaternary mode (`quad_mode`=1) each symbol takes two nibbles. The first nibble's codeword drives `chip_q` and the second nibble's codeword drives `chip_i`.
- R6: `phase_ref`=1 inverts both `chip_i` and `chip_q` relative to `phase_ref`=0.
- R7: While `chip_valid` is high, each cycle with `chip_en` high consumes one chip. A symbol has exactly 8 chips, and `chip_first` is high only on chip 0.
- R8: `bit_ready` is low exactly while a complete next symbol (4 bits in binary mode, 8 bits in quaternary mode) waits in the collector. While it is low, no further bits are taken.
- R9: If a complete symbol is waiting when chip 7 is consumed, the new symbol's chip 0 is presented on the very next cycle, with no gap in `chip_valid`.
- R10: After reset, `chip_valid` is 0 and `bit_ready` is 1. If no complete symbol is waiting when chip 7 is consumed, `chip_valid` drops to 0.
- R11: `chip_en` has no effect while `chip_valid` is low: no chip is skipped or lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| quad_mode | input | 1 | 0 = binary (one nibble per symbol), 1 = quaternary (two nibbles per symbol); change only when the block is idle |
| bit_in | input | 1 | Scrambled data bit |
| bit_valid | input | 1 | `bit_in` is valid |
| bit_ready | output | 1 | Block accepts a bit this cycle |
| phase_ref | input | 1 | Phase-reference bit XORed onto all output chips |
| chip_en | input | 1 | Chip-rate strobe; advances to the next chip |
| chip_valid | output | 1 | A symbol is being emitted; `chip_i`/`chip_q` are meaningful |
| chip_first | output | 1 | The current chip is chip 0 of its symbol |
| chip_i | output | 1 | In-phase chip |
| chip_q | output | 1 | Quadrature chip |

## Verification
On every cycle, the in-RTL assertions check these rules:
- the collector contents stay frozen while a full symbol waits;
- the chip index steps by one per enable and holds without one;
- a waiting symbol is loaded straight after chip 7, and the emitter goes idle when nothing waits;
- I and Q agree in binary mode.

The codeword values, the bit order inside a nibble, the sign and phase inversions and the quaternary Q/I split are shown only by the bench. Its scoreboard compares every emitted chip against values computed from the codeword list. The bench also shows the gap-free back-to-back timing and the ready behaviour at the 4-bit and 8-bit thresholds.

// File: rtl/mbok_pkg.sv
package mbok_pkg;
   // number of nibbles a quaternary symbol carries
   localparam int unsigned MAX_NIBS = 2;

   typedef enum logic {
      MODE_BINARY = 1'b0,
      MODE_QUAD   = 1'b1
   } mbok_mode_e;
endpackage

// File: rtl/mbok_bit_collector.sv
module mbok_bit_collector #(
   parameter int unsigned NIB_W = 4
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                quad_mode,
   input  logic                                bit_in,
   input  logic                                bit_valid,
   output logic                                bit_ready,
   input  logic                                take,
   output logic                                full,
   output logic [mbok_pkg::MAX_NIBS*NIB_W-1:0] nib_buf
);
   localparam int unsigned BUF_W = mbok_pkg::MAX_NIBS * NIB_W;
   localparam int unsigned CNT_W = $clog2(BUF_W + 1);
   localparam int unsigned IDX_W = $clog2(BUF_W);

   if (NIB_W < 2) begin : g_bad_nib
      $error("mbok_bit_collector: NIB_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] target;
   logic             accept;

   // bits needed for one symbol in the current mode
   assign target    = (quad_mode == mbok_pkg::MODE_QUAD) ? CNT_W'(BUF_W) : CNT_W'(NIB_W);
   assign full      = (cnt >= target);
   assign bit_ready = !full;
   assign accept    = bit_valid && bit_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         nib_buf <= '0;
      end else if (take) begin
         cnt <= '0;
      end else if (accept) begin
         // first received bit lands in the lowest position (LSB first)
         nib_buf[cnt[IDX_W-1:0]] <= bit_in;
         cnt                     <= cnt + CNT_W'(1);
      end
   end

   // R8: a waiting symbol is frozen until the sequencer takes it
   property p_hold_when_full;
      @(posedge clk) disable iff (!rst_n)
         (full && !take) |=> ($stable(nib_buf) && $stable(cnt));
   endproperty
   assert_hold_when_full_R8: assert property (p_hold_when_full);

   // R8: the collector never counts past one symbol
   property p_count_bound;
      @(posedge clk) disable iff (!rst_n) cnt <= CNT_W'(BUF_W);
   endproperty
   assert_count_bound_R8: assert property (p_count_bound);
endmodule

// File: rtl/mbok_codeword_gen.sv
module mbok_codeword_gen #(
   parameter int unsigned           CHIPS     = 8,
   parameter bit                    USE_TABLE = 1'b0,
   parameter logic [CHIPS-1:0]      MOD_MASK  = CHIPS'(3),
   localparam int unsigned          MAG_W     = $clog2(CHIPS)
) (
   input  logic [MAG_W-1:0] mag,
   input  logic             sign,
   output logic [CHIPS-1:0] cw
);
   if (CHIPS < 2 || (1 << MAG_W) != CHIPS) begin : g_bad_chips
      $error("mbok_codeword_gen: CHIPS must be a power of two");
   end

   logic [CHIPS-1:0] walsh;

   if (USE_TABLE) begin : g_table
      if (CHIPS != 8) begin : g_bad_table
         $error("mbok_codeword_gen: table variant needs CHIPS == 8");
      end
      // unmodified Walsh rows in magnitude order, chip 0 at bit 0
      always_comb begin
         case (mag)
            MAG_W'(0): walsh = CHIPS'(8'h00);
            MAG_W'(1): walsh = CHIPS'(8'h0F);
            MAG_W'(2): walsh = CHIPS'(8'h33);
            MAG_W'(3): walsh = CHIPS'(8'h3C);
            MAG_W'(4): walsh = CHIPS'(8'h55);
            MAG_W'(5): walsh = CHIPS'(8'h5A);
            MAG_W'(6): walsh = CHIPS'(8'h66);
            default:   walsh = CHIPS'(8'h69);
         endcase
      end
   end else begin : g_compute
      // Hadamard row selected by the bit-reversed magnitude,
      // complemented when the magnitude has odd parity
      logic [MAG_W-1:0] rev;
      always_comb begin
         for (int b = 0; b < MAG_W; b++) begin
            rev[b] = mag[MAG_W-1-b];
         end
         for (int k = 0; k < CHIPS; k++) begin
            walsh[k] = (^(rev & MAG_W'(k))) ^ (^mag);
         end
      end
   end

   // mask removes the all-zero member, sign flips the whole codeword
   assign cw = walsh ^ MOD_MASK ^ {CHIPS{sign}};
endmodule

// File: rtl/mbok_chip_sequencer.sv
module mbok_chip_sequencer #(
   parameter int unsigned CHIPS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chip_en,
   input  logic             sym_ready,
   input  logic [CHIPS-1:0] cw_q_in,
   input  logic [CHIPS-1:0] cw_i_in,
   output logic             take,
   output logic             chip_valid,
   output logic             chip_first,
   output logic             raw_q,
   output logic             raw_i
);
   localparam int unsigned IDX_W = $clog2(CHIPS);

   if (CHIPS < 2) begin : g_bad_chips
      $error("mbok_chip_sequencer: CHIPS must be at least 2");
   end

   logic             active;
   logic [IDX_W-1:0] idx;
   logic [CHIPS-1:0] cw_q;
   logic [CHIPS-1:0] cw_i;
   logic             last;

   assign last = (idx == IDX_W'(CHIPS - 1));
   // load when idle, or right as the final chip is consumed
   assign take = sym_ready && (!active || (chip_en && last));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         idx    <= '0;
         cw_q   <= '0;
         cw_i   <= '0;
      end else if (take) begin
         active <= 1'b1;
         idx    <= '0;
         cw_q   <= cw_q_in;
         cw_i   <= cw_i_in;
      end else if (active && chip_en) begin
         if (last) begin
            active <= 1'b0;
            idx    <= '0;
         end else begin
            idx <= idx + IDX_W'(1);
         end
      end
   end

   assign chip_valid = active;
   assign chip_first = active && (idx == '0);
   assign raw_q      = cw_q[idx];
   assign raw_i      = cw_i[idx];

   // R7: one step per enable inside a symbol
   property p_advance;
      @(posedge clk) disable iff (!rst_n)
         (active && chip_en && !last) |=> (active && idx == $past(idx) + IDX_W'(1));
   endproperty
   assert_chip_advance_R7: assert property (p_advance);

   // R7/R11: no enable, no movement
   property p_hold;
      @(posedge clk) disable iff (!rst_n)
         (active && !chip_en) |=> (active && $stable(idx));
   endproperty
   assert_chip_hold_R11: assert property (p_hold);

   // R9: a waiting symbol starts right after chip 7
   property p_gap_free;
      @(posedge clk) disable iff (!rst_n)
         (active && chip_en && last && sym_ready) |=> (active && idx == '0);
   endproperty
   assert_gap_free_R9: assert property (p_gap_free);

   // R10: nothing waiting means the emitter goes idle
   property p_go_idle;
      @(posedge clk) disable iff (!rst_n)
         (active && chip_en && last && !sym_ready) |=> !active;
   endproperty
   assert_go_idle_R10: assert property (p_go_idle);
endmodule

// File: rtl/mbok_chip_modulator.sv
module mbok_chip_modulator #(
   parameter int unsigned CHIPS     = 8,
   parameter bit          USE_TABLE = 1'b0,
   parameter logic [CHIPS-1:0] MOD_MASK = CHIPS'(3)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic quad_mode,
   input  logic bit_in,
   input  logic bit_valid,
   output logic bit_ready,
   input  logic phase_ref,
   input  logic chip_en,
   output logic chip_valid,
   output logic chip_first,
   output logic chip_i,
   output logic chip_q
);
   localparam int unsigned MAG_W = $clog2(CHIPS);
   localparam int unsigned NIB_W = MAG_W + 1;
   localparam int unsigned NIBS  = mbok_pkg::MAX_NIBS;

   logic [NIBS*NIB_W-1:0] nib_buf;
   logic                  full;
   logic                  take;
   logic [CHIPS-1:0]      cw [NIBS];
   logic [CHIPS-1:0]      cw_i_sel;
   logic                  raw_q;
   logic                  raw_i;

   mbok_bit_collector #(.NIB_W(NIB_W)) collector_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .quad_mode (quad_mode),
      .bit_in    (bit_in),
      .bit_valid (bit_valid),
      .bit_ready (bit_ready),
      .take      (take),
      .full      (full),
      .nib_buf   (nib_buf)
   );

   // one codeword generator per nibble slot
   for (genvar n = 0; n < NIBS; n++) begin : g_nib
      mbok_codeword_gen #(
         .CHIPS     (CHIPS),
         .USE_TABLE (USE_TABLE),
         .MOD_MASK  (MOD_MASK)
      ) gen_i (
         .mag  (nib_buf[n*NIB_W +: MAG_W]),
         .sign (nib_buf[n*NIB_W + MAG_W]),
         .cw   (cw[n])
      );
   end

   // quaternary: second nibble on I; binary: first nibble on both
   assign cw_i_sel = (quad_mode == mbok_pkg::MODE_QUAD) ? cw[1] : cw[0];

   mbok_chip_sequencer #(.CHIPS(CHIPS)) sequencer_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .chip_en    (chip_en),
      .sym_ready  (full),
      .cw_q_in    (cw[0]),
      .cw_i_in    (cw_i_sel),
      .take       (take),
      .chip_valid (chip_valid),
      .chip_first (chip_first),
      .raw_q      (raw_q),
      .raw_i      (raw_i)
   );

   assign chip_q = raw_q ^ phase_ref;
   assign chip_i = raw_i ^ phase_ref;

   // R4: binary mode drives identical chips on both rails
   property p_binary_iq;
      @(posedge clk) disable iff (!rst_n)
         (chip_valid && quad_mode == mbok_pkg::MODE_BINARY) |-> (chip_i == chip_q);
   endproperty
   assert_binary_iq_R4: assert property (p_binary_iq);
endmodule

// File: tb/mbok_chip_modulator_tb.sv
`timescale 1ns/1ps
module mbok_chip_modulator_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic quad_mode = 1'b0;
   logic bit_in = 1'b0;
   logic bit_valid = 1'b0;
   logic bit_ready;
   logic phase_ref = 1'b0;
   logic chip_en = 1'b0;
   logic chip_valid, chip_first, chip_i, chip_q;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int en_period = 0;
   bit mon_on = 1'b0;
   logic [2:0] expq[$];   // {first, i, q}
   int pops = 0;
   int first_pop = -1;
   int last_pop = -1;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   mbok_chip_modulator dut_i (
      .clk(clk), .rst_n(rst_n), .quad_mode(quad_mode),
      .bit_in(bit_in), .bit_valid(bit_valid), .bit_ready(bit_ready),
      .phase_ref(phase_ref), .chip_en(chip_en),
      .chip_valid(chip_valid), .chip_first(chip_first),
      .chip_i(chip_i), .chip_q(chip_q)
   );

   function automatic logic [7:0] ref_cw(int mag);
      case (mag)
         0: return 8'h03;  1: return 8'h0C;  2: return 8'h30;  3: return 8'h3F;
         4: return 8'h56;  5: return 8'h59;  6: return 8'h65;  default: return 8'h6A;
      endcase
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // cycle counter and chip-enable pattern, driven after the edge
   always @(posedge clk) begin
      cyc <= cyc + 1;
      #1;
      chip_en <= (en_period != 0) && ((cyc % en_period) == 0);
   end

   // monitor: pops an expected chip every consumed chip (R2 R3 R5 R6 R7 R11)
   always @(negedge clk) begin
      if (mon_on && chip_valid && chip_en) begin
         if (expq.size() == 0) begin
            check(1'b0, "R7 unexpected chip", {chip_i, chip_q}, 0);
         end else begin
            logic [2:0] e;
            logic ei, eq;
            e  = expq.pop_front();
            ei = e[1] ^ phase_ref;
            eq = e[0] ^ phase_ref;
            check({chip_first, chip_i, chip_q} == {e[2], ei, eq},
                  "R2/R3/R5/R6/R7 chip", {chip_first, chip_i, chip_q}, {e[2], ei, eq});
            pops++;
            if (first_pop < 0) first_pop = cyc;
            last_pop = cyc;
         end
      end
   end

   task automatic send_bit(logic b);
      bit_valid = 1'b1;
      bit_in    = b;
      while (!bit_ready) begin @(posedge clk); #1; end
      @(posedge clk); #1;
      bit_valid = 1'b0;
   endtask

   // R1: magnitude LSB first, sign last
   task automatic send_nibble(int mag, int sgn);
      send_bit(mag[0]); send_bit(mag[1]); send_bit(mag[2]); send_bit(sgn[0]);
   endtask

   task automatic send_symbol(int m0, int s0, int m1, int s1);
      logic [7:0] c0, c1;
      c0 = ref_cw(m0) ^ {8{s0[0]}};
      c1 = ref_cw(m1) ^ {8{s1[0]}};
      for (int k = 0; k < 8; k++) begin
         logic iv;
         iv = quad_mode ? c1[k] : c0[k];
         expq.push_back({(k == 0), iv, c0[k]});
      end
      send_nibble(m0, s0);
      if (quad_mode) send_nibble(m1, s1);
   endtask

   task automatic wait_drain();
      int guard = 0;
      while ((expq.size() != 0 || chip_valid) && guard < 2000) begin
         @(posedge clk); #1; guard++;
      end
      check(expq.size() == 0, "R10 drain", expq.size(), 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         check(1'b0, "watchdog", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stimulus
      repeat (3) @(posedge clk);
      #1;
      // R10: reset state
      check(chip_valid == 1'b0, "R10 reset chip_valid", chip_valid, 0);
      check(bit_ready == 1'b1, "R10 reset bit_ready", bit_ready, 1);
      rst_n = 1'b1;
      mon_on = 1'b1;

      // R11: enable pulses while idle, then binary burst gap-free (R1 R2 R3 R4 R9)
      en_period = 1;
      repeat (6) @(posedge clk); #1;
      pops = 0; first_pop = -1;
      for (int m = 0; m < 8; m++) send_symbol(m, m % 2, 0, 0);
      wait_drain();
      check(pops == 64, "R7 chips per symbol", pops, 64);
      check(last_pop - first_pop + 1 == pops, "R9 gap-free", last_pop - first_pop + 1, pops);
      check(bit_ready == 1'b1, "R10 ready when idle", bit_ready, 1);
      check(chip_valid == 1'b0, "R10 idle after drain", chip_valid, 0);

      // R6: phase reference inverts both rails
      phase_ref = 1'b1;
      for (int m = 7; m >= 0; m--) send_symbol(m, (m / 2) % 2, 0, 0);
      wait_drain();
      phase_ref = 1'b0;

      // R5: quaternary, throttled chip enable
      quad_mode = 1'b1;
      en_period = 3;
      for (int m = 0; m < 8; m++) send_symbol(m, m % 2, 7 - m, (m / 3) % 2);
      wait_drain();

      // R8: ready thresholds with chips stalled, quaternary
      en_period = 0;
      repeat (2) @(posedge clk); #1;
      send_symbol(3, 0, 5, 1);
      repeat (2) @(posedge clk); #1;
      check(chip_valid == 1'b1, "R10 loaded while stalled", chip_valid, 1);
      check(chip_first == 1'b1, "R7 first chip held", chip_first, 1);
      begin
         logic [7:0] c0, c1;
         c0 = ref_cw(6); c1 = ref_cw(2) ^ 8'hFF;
         for (int k = 0; k < 8; k++) expq.push_back({(k == 0), c1[k], c0[k]});
      end
      send_nibble(6, 0);
      check(bit_ready == 1'b1, "R8 ready after 4 of 8", bit_ready, 1);
      send_nibble(2, 1);
      repeat (3) @(posedge clk); #1;
      check(bit_ready == 1'b0, "R8 not ready with symbol waiting", bit_ready, 0);
      en_period = 2;
      wait_drain();

      // R8: binary threshold at 4 bits
      quad_mode = 1'b0;
      en_period = 0;
      repeat (2) @(posedge clk); #1;
      send_symbol(4, 1, 0, 0);
      send_symbol(1, 0, 0, 0);
      repeat (3) @(posedge clk); #1;
      check(bit_ready == 1'b0, "R8 binary full at 4 bits", bit_ready, 0);
      en_period = 1;
      wait_drain();
      check(bit_ready == 1'b1, "R8 ready after take", bit_ready, 1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule